// File: doc/BRIEF.md
# CRC-8 Coded Word Checker

This block validates a 24-bit coded word made of a 16-bit data field and an 8-bit check byte. It recomputes the CRC-8 of the data field with the generator x^8+x^7+x^6+x^4+x^2+1. It then compares that value bit by bit with the check byte that came with the word. The result is reported two ways: an 8-bit syndrome with a 1 in every check position that disagrees, and a single error flag that is raised when any syndrome bit is set.

The checker sits on the receive side of a link or storage path, after an encoder that uses the same generator. A new word can be presented on every clock. Both outputs are registered, so the verdict for a word appears one clock after it is sampled. The block does not correct errors or say which data bit was hit.

Top module: `crc_word_checker`

## Requirements
- R1: The word is split as data = word_i[23:8] and received check = word_i[7:0]. word_i[23] is the highest-degree data coefficient.
- R2: The recomputed check is the remainder of data(x)*x^8 divided by the generator 0x1D5. The remainder starts at zero and uses no bit reflection and no final inversion. Data is consumed from word_i[23] down to word_i[8].
- R3: syndrome_o[i] is 1 exactly when bit i of the recomputed check differs from word_i[i], for i = 0..7.
- R4: error_o is 1 exactly when syndrome_o is nonzero.
- R5: A word whose low byte equals the CRC of its upper 16 bits yields syndrome_o = 0 and error_o = 0.
- R6: Flipping any single bit of a valid word raises error_o, and the syndrome equals that bit's weight x^k reduced modulo the generator.
- R7: Flipping any two distinct bits of a valid word raises error_o.
- R8: Outputs are registered. The values seen after rising edge k describe the word sampled at edge k, and they hold until the next edge.
- R9: A synchronous active-high rst drives syndrome_o to 0 and error_o to 0 at each edge where it is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 24 | Coded word: data in [23:8], received check in [7:0] |
| syndrome_o | output | 8 | Per-bit mismatch between recomputed and received check |
| error_o | output | 1 | High when any syndrome bit is set |

## Verification
The bench applies words whose check bytes were worked out by hand, covering the all-zero word, a single data bit at either end of the field, and the all-ones data field. A design with a reversed data order or a wrong polynomial tap would give nonzero syndromes on these clean words. Every single-bit position is flipped on several valid words, every two-bit pattern is tried on one word, and random two-bit flips are applied on random words. A checker that drops a bit from the division, or ORs only part of the syndrome, would leave some of these flips unflagged. Further directed steps check the outputs while the input changes before the next edge, and apply a reset in the middle of traffic. A design that passes the word straight through without a register, or ignores reset, would be caught there.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;
  localparam int unsigned DATA_W_DEF = 16;
  localparam int unsigned CRC_W_DEF  = 8;
  // Generator without its leading x^8 term: x^7+x^6+x^4+x^2+1
  localparam logic [7:0]  POLY_DEF   = 8'hD5;
endpackage

// File: rtl/crc_div_stage.sv
// One step of polynomial division: absorb one data bit into the remainder.
module crc_div_stage #(
  parameter int unsigned CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY = 8'hD5
) (
  input  logic [CRC_W-1:0] rem_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] rem_o
);
  logic feedback;

  always_comb begin
    feedback = rem_i[CRC_W-1] ^ bit_i;
    rem_o    = {rem_i[CRC_W-2:0], 1'b0} ^ (feedback ? POLY : '0);
  end
endmodule

// File: rtl/crc_remainder.sv
// Unrolled chain of division steps, most significant data bit first.
module crc_remainder #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CRC_W  = 8,
  parameter logic [CRC_W-1:0] POLY = 8'hD5
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [DATA_W:0][CRC_W-1:0] chain;

  assign chain[0] = '0;

  for (genvar g = 0; g < DATA_W; g++) begin : g_step
    crc_div_stage #(
      .CRC_W (CRC_W),
      .POLY  (POLY)
    ) u_stage (
      .rem_i (chain[g]),
      .bit_i (data_i[DATA_W-1-g]),
      .rem_o (chain[g+1])
    );
  end

  assign crc_o = chain[DATA_W];
endmodule

// File: rtl/crc_syndrome.sv
// Per-bit mismatch vector and its OR reduction.
module crc_syndrome #(
  parameter int unsigned CRC_W = 8
) (
  input  logic [CRC_W-1:0] calc_i,
  input  logic [CRC_W-1:0] rx_i,
  output logic [CRC_W-1:0] syn_o,
  output logic             flag_o
);
  for (genvar b = 0; b < CRC_W; b++) begin : g_bit
    assign syn_o[b] = calc_i[b] ^ rx_i[b];
  end

  assign flag_o = |syn_o;
endmodule

// File: rtl/crc_word_checker.sv
module crc_word_checker
  import crc_chk_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned CRC_W  = CRC_W_DEF,
  parameter logic [CRC_W-1:0] POLY = POLY_DEF,
  localparam int unsigned WORD_W = DATA_W + CRC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  output logic [CRC_W-1:0]  syndrome_o,
  output logic              error_o
);
  logic [DATA_W-1:0] data_field;
  logic [CRC_W-1:0]  rx_check;
  logic [CRC_W-1:0]  calc_check;
  logic [CRC_W-1:0]  syn_d;
  logic              err_d;
  logic [CRC_W-1:0]  syn_q;
  logic              err_q;
  logic              prime_q;

  assign data_field = word_i[WORD_W-1:CRC_W];
  assign rx_check   = word_i[CRC_W-1:0];

  crc_remainder #(
    .DATA_W (DATA_W),
    .CRC_W  (CRC_W),
    .POLY   (POLY)
  ) u_rem (
    .data_i (data_field),
    .crc_o  (calc_check)
  );

  crc_syndrome #(
    .CRC_W (CRC_W)
  ) u_syn (
    .calc_i (calc_check),
    .rx_i   (rx_check),
    .syn_o  (syn_d),
    .flag_o (err_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      syn_q   <= '0;
      err_q   <= 1'b0;
      prime_q <= 1'b0;
    end else begin
      syn_q   <= syn_d;
      err_q   <= err_d;
      prime_q <= 1'b1;
    end
  end

  assign syndrome_o = syn_q;
  assign error_o    = err_q;

  // R9: reset clears both outputs on the following edge
  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (syn_q == '0 && !err_q));

  // R4: flag agrees with the registered syndrome
  assert_flag_or_R4: assert property (@(posedge clk) disable iff (rst)
    prime_q |-> (err_q == (syn_q != '0)));

  // R8: a held input gives held outputs
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (prime_q && $stable(word_i)) |=> ($stable(syn_q) && $stable(err_q)));

  // R5: a matching check byte never raises the flag
  assert_clean_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_check == calc_check) |=> !err_q);
endmodule

// File: tb/crc_word_checker_bench.sv
module crc_word_checker_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [23:0] word;
  logic [7:0]  syn;
  logic        err;
  int          n_checks = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  crc_word_checker u_crc_word_checker (
    .clk        (clk),
    .rst        (rst),
    .word_i     (word),
    .syndrome_o (syn),
    .error_o    (err)
  );

  // {word, expected syndrome}, values worked out by hand
  localparam logic [31:0] VEC [11] = '{
    {24'h000000, 8'h00},
    {24'h00122D, 8'h00},
    {24'h0001D5, 8'h00},
    {24'h8000AB, 8'h00},
    {24'h01000B, 8'h00},
    {24'hFFFF81, 8'h00},
    {24'h001200, 8'h2D},
    {24'h000012, 8'h12},
    {24'h000100, 8'hD5},
    {24'h800100, 8'h7E},
    {24'h81017E, 8'h0B}
  };

  // Long division of the whole 24-bit word by the generator
  function automatic logic [7:0] word_rem(input logic [23:0] w);
    logic [23:0] r = w;
    for (int b = 23; b >= 8; b--)
      if (r[b]) r = r ^ (24'h0001D5 << (b - 8));
    return r[7:0];
  endfunction

  function automatic logic [23:0] make_valid(input logic [15:0] d);
    return {d, word_rem({d, 8'h00})};
  endfunction

  task automatic check(input string tag, input logic [7:0] exp_syn, input logic exp_err);
    n_checks++;
    if (syn !== exp_syn || err !== exp_err) begin
      n_fail++;
      $display("FAIL %s: got syn=%02h err=%0b, expected syn=%02h err=%0b",
               tag, syn, err, exp_syn, exp_err);
    end
  endtask

  task automatic apply(input logic [23:0] w);
    @(negedge clk);
    word = w;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] v;
    logic [23:0] bad;
    rst  = 1'b1;
    word = 24'h000012;
    repeat (3) @(negedge clk);
    check("R9 reset state", 8'h00, 1'b0);
    rst = 1'b0;

    // Table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < 11; i++) begin
      apply(VEC[i][31:8]);
      check("R1/R2/R3 table", VEC[i][7:0], VEC[i][7:0] != 8'h00);
    end

    // R8: outputs hold until the next rising edge
    apply(24'h001200);
    word = 24'h00122D;
    #5;
    check("R8 hold before edge", 8'h2D, 1'b1);
    @(negedge clk);
    check("R8 update after edge", 8'h00, 1'b0);

    // R9: reset in mid traffic
    apply(24'h000100);
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid reset", 8'h00, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 release", 8'hD5, 1'b1);

    // R5: clean random words
    for (int i = 0; i < 100; i++) begin
      apply(make_valid(16'($urandom())));
      check("R5 clean word", 8'h00, 1'b0);
    end

    // R6: every single-bit flip on several valid words
    for (int k = 0; k < 4; k++) begin
      v = make_valid(16'(k * 16'h4A7B + 16'h0313));
      for (int p = 0; p < 24; p++) begin
        bad = v ^ (24'h1 << p);
        apply(bad);
        check("R6 single flip", word_rem(24'h1 << p), 1'b1);
      end
    end

    // R7: every two-bit flip on one valid word
    v = make_valid(16'hC3A5);
    for (int p = 0; p < 24; p++) begin
      for (int q = p + 1; q < 24; q++) begin
        bad = v ^ (24'h1 << p) ^ (24'h1 << q);
        apply(bad);
        check("R7 double flip", word_rem(bad), 1'b1);
      end
    end

    // R7: random two-bit flips on random words
    for (int i = 0; i < 200; i++) begin
      int p;
      int q;
      v = make_valid(16'($urandom()));
      p = $urandom_range(23, 0);
      q = (p + 1 + $urandom_range(22, 0)) % 24;
      bad = v ^ (24'h1 << p) ^ (24'h1 << q);
      apply(bad);
      check("R7 random double flip", word_rem(bad), 1'b1);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule